// File: doc/BRIEF.md
# Z80 Bus Master Access Engine

This engine lets a local controller borrow the system bus of a Z80-style processor and run memory accesses on it. The local side asks for the bus with one command. The engine pulls the bus-request line low and waits for the acknowledge. Only then does it turn on the drivers of the address lines that have no external buffer. While it holds the bus, the controller can issue single-byte reads and writes. It can also issue fills, which write one value over a range, and block writes, which take one streamed byte per address. A last command hands the bus back, and that command reports done only once the processor has dropped its acknowledge.

Every access is a fixed series of steps, and each step lasts `STEP` clock cycles. During a fill or a block write the memory request stays low for the whole run. The write strobe pulses once per byte, and the address advances by one after each byte. A command given while the bus is not held is refused with an error, and so is an unknown operation code. A fill or block write of length zero ends at once and never touches the bus.

Top module: `zbus_master`

## Requirements
- R1: After reset, `mreq_n`, `rd_n`, `wr_n`, `busreq_n` and `nmi_n` are high, `addr_oe` and `data_oe` are low, and `done` is low.
- R2: Operation code 0 (acquire) drives `busreq_n` low. `addr_oe` rises only after `busack_n` reads low, and `done` follows without `err`. An acquire while the bus is already held completes with no error.
- R3: Operation code 1 (release) first keeps the data bus as input, then lowers `addr_oe`, then raises `busreq_n`. It pulses `done` only once `busack_n` reads high.
- R4: Operation code 3 (single write) drives the address, lowers `mreq_n`, drives the data with `data_oe` high, and pulses `wr_n` low for exactly `STEP` cycles. It then raises `mreq_n`, so the byte lands at the address.
- R5: Operation code 2 (single read) lowers `mreq_n` with `data_oe` low. It holds `rd_n` low for `2*STEP` cycles, samples `data_in` at the end of that window, and returns the byte on `rdata` with `done`.
- R6: Operation code 4 (fill) writes `cmd_wdata` to `cmd_len` consecutive addresses starting at `cmd_addr`. `mreq_n` falls exactly once for the whole run, with one `wr_n` pulse per byte.
- R7: Operation code 5 (block write) writes `cmd_len` bytes to consecutive addresses under a single `mreq_n` assertion. It latches `cmd_wdata` once per byte and pulses `data_take` each time, the first at the start.
- R8: A read, write, fill, block write or release issued while the bus is not held pulses `done` together with `err`, and `mreq_n` never falls.
- R9: A fill or block write with `cmd_len` equal to 0 pulses `done` without `err`, and `mreq_n` never falls.
- R10: Operation codes 6 and 7 pulse `done` with `err` and cause no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle command strobe, taken only when idle |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 19 | Start address |
| cmd_wdata | input | 8 | Write data, fill value or streamed block byte |
| cmd_len | input | 16 | Byte count for fill and block write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejection flag, valid with done |
| rdata | output | 8 | Byte returned by a read |
| data_take | output | 1 | Pulse when a block-write byte has been latched |
| busreq_n | output | 1 | Bus request, active low |
| busack_n | input | 1 | Bus acknowledge, active low |
| bus_addr | output | 19 | Address bus value |
| addr_oe | output | 1 | Drive enable of the unbuffered address lines |
| data_out | output | 8 | Data bus value when driving |
| data_oe | output | 1 | Data bus drive enable |
| data_in | input | 8 | Data bus value when reading |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| nmi_n | output | 1 | Non-maskable interrupt line, held inactive high |

## Verification
The assertions assume two things about the processor model. It lowers `busack_n` only while a request is pending, and it holds the acknowledge steady while the bus is in use. The bench models the acknowledge as a three-cycle delayed copy of `busreq_n`, so both assumptions always hold. The assertions also assume that `cmd_start` pulses only while the engine is idle. The bench raises it only after the previous `done` has been seen. Read data comes from a small memory model that drives `data_in` only while `rd_n` is low. Write data is captured on the rising edge of `wr_n`.

// File: rtl/zbus_master.sv
module zbus_master #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              data_take,
  output logic              busreq_n,
  input  logic              busack_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [DATA_W-1:0] data_in,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              nmi_n
);
  localparam int TW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [2:0] OP_ACQ = 3'd0, OP_REL = 3'd1, OP_RD = 3'd2,
                         OP_WR = 3'd3, OP_FILL = 3'd4, OP_BLK = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_ACQ, S_REL_D, S_REL_A, S_REL_W,
    S_ADDR, S_MREQ, S_DATA, S_STRB, S_HOLD, S_END
  } st_t;

  st_t              st;
  logic [TW-1:0]    tick;
  logic [LEN_W-1:0] remain;
  logic             rd_op, blk_op, req, aoe;
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] dout_r;

  wire last    = (tick == TW'(STEP - 1));
  wire untimed = (st == S_IDLE) || (st == S_ACQ) || (st == S_REL_W);
  wire multi   = (cmd_op == OP_FILL) || (cmd_op == OP_BLK);
  wire in_req  = (st == S_MREQ) || (st == S_DATA) || (st == S_STRB) || (st == S_HOLD);

  assign mreq_n   = !in_req;
  assign rd_n     = !(rd_op && ((st == S_STRB) || (st == S_HOLD)));
  assign wr_n     = !(!rd_op && (st == S_STRB));
  assign data_oe  = !rd_op && ((st == S_DATA) || (st == S_STRB) || (st == S_HOLD));
  assign busreq_n = !req;
  assign addr_oe  = aoe;
  assign bus_addr = addr_r;
  assign data_out = dout_r;
  assign nmi_n    = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || untimed || last) tick <= '0;
    else                           tick <= tick + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; remain <= '0; rd_op <= 1'b0; blk_op <= 1'b0;
      req <= 1'b0; aoe <= 1'b0; addr_r <= '0; dout_r <= '0;
      rdata <= '0; done <= 1'b0; err <= 1'b0; data_take <= 1'b0;
    end else begin
      done <= 1'b0; err <= 1'b0; data_take <= 1'b0;
      case (st)
        S_IDLE: if (cmd_start) begin
          case (cmd_op)
            OP_ACQ: if (aoe) done <= 1'b1;
                    else begin req <= 1'b1; st <= S_ACQ; end
            OP_REL: if (!aoe) begin done <= 1'b1; err <= 1'b1; end
                    else st <= S_REL_D;
            OP_RD, OP_WR, OP_FILL, OP_BLK:
              if (!aoe) begin done <= 1'b1; err <= 1'b1; end
              else if (multi && cmd_len == '0) done <= 1'b1;
              else begin
                addr_r    <= cmd_addr;
                dout_r    <= cmd_wdata;
                rd_op     <= (cmd_op == OP_RD);
                blk_op    <= (cmd_op == OP_BLK);
                remain    <= multi ? cmd_len : LEN_W'(1);
                data_take <= (cmd_op == OP_BLK);
                st        <= S_ADDR;
              end
            default: begin done <= 1'b1; err <= 1'b1; end
          endcase
        end
        S_ACQ:   if (!busack_n) begin aoe <= 1'b1; done <= 1'b1; st <= S_IDLE; end
        S_REL_D: if (last) begin aoe <= 1'b0; st <= S_REL_A; end
        S_REL_A: if (last) begin req <= 1'b0; st <= S_REL_W; end
        S_REL_W: if (busack_n) begin done <= 1'b1; st <= S_IDLE; end
        S_ADDR:  if (last) st <= S_MREQ;
        S_MREQ:  if (last) st <= S_DATA;
        S_DATA:  if (last) st <= S_STRB;
        S_STRB:  if (last) st <= S_HOLD;
        S_HOLD:  if (last) begin
          if (rd_op) rdata <= data_in;
          remain <= remain - 1'b1;
          if (remain > LEN_W'(1)) begin
            addr_r <= addr_r + 1'b1;
            if (blk_op) begin dout_r <= cmd_wdata; data_take <= 1'b1; end
            st <= S_DATA;
          end else st <= S_END;
        end
        S_END:   if (last) begin done <= 1'b1; rd_op <= 1'b0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!mreq_n && data_oe && rd_n)); // R4
  AST_RD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!mreq_n && !data_oe && wr_n)); // R5
  AST_RD_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n); // R5
  AST_ADDR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> (!busack_n && !busreq_n)); // R2
  AST_REL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busreq_n) |-> (!addr_oe && !data_oe)); // R3
  AST_MREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mreq_n |-> (addr_oe && !busreq_n)); // R8
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R8
  AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(bus_addr) && $stable(data_out))); // R4
endmodule

// File: tb/zbus_master_tb.sv
module zbus_master_tb_top;
  localparam int STEP = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_start = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [18:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic [15:0] cmd_len = '0;
  logic done, err, data_take, busreq_n, addr_oe, data_oe, mreq_n, rd_n, wr_n, nmi_n;
  logic [7:0]  rdata, data_out, data_in;
  logic [18:0] bus_addr;
  logic [2:0]  ack_sr;
  logic        busack_n;

  logic [7:0] mem [0:1023];
  logic [7:0] blk [0:7];
  int bidx, takes, mreq_falls, wr_pulses, rd_pulses, wlow, rlow;
  bit wbad, rbad, ackbad, relbad, p_mreq, p_wr, p_rd, p_aoe, p_req;
  int total = 0, bad = 0;
  logic got_err; logic [7:0] got_rd;

  zbus_master #(.STEP(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .done(done), .err(err), .rdata(rdata), .data_take(data_take),
    .busreq_n(busreq_n), .busack_n(busack_n), .bus_addr(bus_addr),
    .addr_oe(addr_oe), .data_out(data_out), .data_oe(data_oe),
    .data_in(data_in), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .nmi_n(nmi_n));

  always @(posedge clk) ack_sr <= !rst_n ? 3'b111 : {ack_sr[1:0], busreq_n};
  assign busack_n = ack_sr[2];
  assign data_in  = !rd_n ? mem[bus_addr[9:0]] : 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_mreq && !mreq_n) mreq_falls++;
      if (!wr_n) wlow++;
      if (!rd_n) rlow++;
      if (!p_wr && wr_n) begin
        wr_pulses++; if (wlow != STEP) wbad = 1;
        mem[bus_addr[9:0]] = data_out; wlow = 0;
      end
      if (!p_rd && rd_n) begin rd_pulses++; if (rlow != 2*STEP) rbad = 1; rlow = 0; end
      if (!wr_n && (mreq_n || !data_oe)) wbad = 1;
      if (!rd_n && (mreq_n || data_oe)) rbad = 1;
      if (addr_oe && busack_n) ackbad = 1;
      if (p_aoe && !addr_oe && (busreq_n || data_oe)) relbad = 1;
      if (!p_req && busreq_n && addr_oe) relbad = 1;
      if (data_take) begin takes++; bidx++; cmd_wdata = blk[bidx[2:0]]; end
    end
    p_mreq = mreq_n; p_wr = wr_n; p_rd = rd_n; p_aoe = addr_oe; p_req = busreq_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [18:0] a,
                         input logic [7:0] wd, input logic [15:0] ln);
    int n;
    @(posedge clk); #1;
    mreq_falls = 0; wr_pulses = 0; rd_pulses = 0; takes = 0; bidx = 0;
    wbad = 0; rbad = 0; ackbad = 0; relbad = 0;
    cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_len = ln; cmd_start = 1'b1;
    @(posedge clk); #1; cmd_start = 1'b0;
    n = 0; got_err = 1'bx;
    while (n < 3000) begin
      @(negedge clk); n++;
      if (done) begin got_err = err; got_rd = rdata; break; end
    end
    check(n < 3000, "done-timeout", n, 0);
  endtask

  task automatic t_reset;
    check(mreq_n && rd_n && wr_n && busreq_n && nmi_n, "R1 strobes", {mreq_n,rd_n,wr_n,busreq_n,nmi_n}, 5'h1f);
    check(!addr_oe && !data_oe && !done, "R1 enables", {addr_oe,data_oe,done}, 0);
  endtask

  task automatic t_unheld;
    run_cmd(3'd3, 19'h10, 8'hAA, 0);
    check(got_err === 1'b1, "R8 write unheld err", got_err, 1);
    check(mreq_falls == 0 && mem[10'h10] == 8'h00, "R8 no bus", mreq_falls, 0);
    run_cmd(3'd1, 0, 0, 0);
    check(got_err === 1'b1, "R8 release unheld err", got_err, 1);
  endtask

  task automatic t_acquire;
    run_cmd(3'd0, 0, 0, 0);
    check(got_err === 1'b0 && !busreq_n && addr_oe, "R2 held", {got_err,busreq_n,addr_oe}, 3'b001);
    check(!ackbad, "R2 oe after ack", ackbad, 0);
    run_cmd(3'd0, 0, 0, 0);
    check(got_err === 1'b0 && addr_oe, "R2 reacquire", got_err, 0);
  endtask

  task automatic t_single;
    run_cmd(3'd3, 19'h00123, 8'h5A, 0);
    check(mem[10'h123] == 8'h5A, "R4 write data", mem[10'h123], 8'h5A);
    check(mreq_falls == 1 && wr_pulses == 1 && !wbad, "R4 write framing", {mreq_falls,wr_pulses,wbad}, 0);
    run_cmd(3'd2, 19'h00123, 0, 0);
    check(got_rd == 8'h5A, "R5 read back", got_rd, 8'h5A);
    check(rd_pulses == 1 && !rbad && wr_pulses == 0, "R5 read strobe", rd_pulses, 1);
    run_cmd(3'd2, 19'h7F0F0, 0, 0);
    check(got_rd == 8'h96, "R5 read preload", got_rd, 8'h96);
  endtask

  task automatic t_fill;
    run_cmd(3'd4, 19'h00200, 8'hC3, 5);
    for (int i = 0; i < 5; i++)
      check(mem[10'h200 + i] == 8'hC3, "R6 fill byte", mem[10'h200 + i], 8'hC3);
    check(mem[10'h205] == 8'h00, "R6 fill end", mem[10'h205], 0);
    check(mreq_falls == 1 && wr_pulses == 5 && !wbad, "R6 one mreq", mreq_falls, 1);
  endtask

  task automatic t_block;
    blk[0] = 8'h11; blk[1] = 8'h22; blk[2] = 8'h33; blk[3] = 8'h44;
    run_cmd(3'd5, 19'h00300, 8'h11, 4);
    for (int i = 0; i < 4; i++)
      check(mem[10'h300 + i] == blk[i], "R7 block byte", mem[10'h300 + i], blk[i]);
    check(mreq_falls == 1 && wr_pulses == 4 && takes == 4, "R7 stream", {mreq_falls,wr_pulses,takes}, 0);
  endtask

  task automatic t_zero;
    run_cmd(3'd4, 19'h00400, 8'h77, 0);
    check(got_err === 1'b0 && mreq_falls == 0 && mem[10'h400] == 0, "R9 fill zero", mreq_falls, 0);
    run_cmd(3'd5, 19'h00400, 8'h77, 0);
    check(got_err === 1'b0 && mreq_falls == 0 && takes == 0, "R9 block zero", takes, 0);
  endtask

  task automatic t_badop;
    run_cmd(3'd6, 19'h00500, 8'h99, 1);
    check(got_err === 1'b1 && mreq_falls == 0, "R10 op6", got_err, 1);
    run_cmd(3'd7, 19'h00500, 8'h99, 1);
    check(got_err === 1'b1 && mem[10'h500] == 0, "R10 op7", got_err, 1);
  endtask

  task automatic t_release;
    run_cmd(3'd1, 0, 0, 0);
    check(got_err === 1'b0 && busack_n && busreq_n && !addr_oe, "R3 released", {busack_n,busreq_n,addr_oe}, 3'b110);
    check(!relbad, "R3 order", relbad, 0);
    run_cmd(3'd2, 19'h00123, 0, 0);
    check(got_err === 1'b1 && rd_pulses == 0, "R8 read after release", got_err, 1);
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[10'h0F0] = 8'h96;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unheld();
    t_acquire();
    t_single();
    t_fill();
    t_block();
    t_zero();
    t_badop();
    t_release();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule